// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is a four-wire boundary-scan test port for the pin ring of a chip. A test clock (`tck`), a mode select (`tms`) and a serial input (`tdi`) walk a 16-state controller. The controller moves bits through a 3-bit instruction register and one of three data registers: a 1-bit bypass stage, a 32-bit identification word, and a boundary register. The boundary register holds three cells for every I/O, and its length follows from a parameter. Serial data leaves on `tdo`, together with an enable that is high only while bits are being shifted.

The instruction register picks the register that sits in the serial path and what drives the pins. In normal operation the pins carry the core's own output data and enables. Test instructions can preload the boundary cells and then drive the pins from them, float every output, or freeze the pins while the short bypass path stays selected. There is no separate test-reset pin. A synchronous power-on reset (`por`) and a run of TMS-high clocks both return the controller to its reset state. Pads are not modelled: the pin side is a set of plain vectors.

Top module: `scan_tap_port`

## Requirements
- R1: After `por`, and on every clock spent in Test-Logic-Reset, the instruction register holds IDCODE (010). A data scan with no instruction load therefore returns the 32-bit identification word, least significant bit first. Its fields are bits [7:0] a fixed byte 0x2F, bits [11:8] the ID number, bits [27:12] the part number and bits [31:28] the version.
- R2: Five consecutive rising TCK edges with `tms` high put the controller in Test-Logic-Reset from any state. Holding `tms` high keeps it there.
- R3: `tms` and `tdi` are sampled on the rising edge of `tck`. `tdo` changes only on the falling edge.
- R4: `tdo_oe` is high only while the controller is in Shift-IR or Shift-DR, and `tdo` reads 0 whenever `tdo_oe` is low.
- R5: Capture-IR loads 001 into the instruction shift stage, so the first three bits shifted out of an instruction scan are 1, 0, 0.
- R6: Opcodes 111, 011 and 100 select the bypass stage. It captures 0 and delays `tdi` by one shift.
- R7: The boundary register has three cells per I/O i. Cell 3i captures `pad_in[i]`, cell 3i+1 captures `core_out[i]` and cell 3i+2 captures `core_oe[i]`. Capture happens in Capture-DR under EXTEST (000) or SAMPLE/PRELOAD (001). Cell 0 is shifted out first, and `tdi` enters the highest cell.
- R8: The boundary update stage changes only on the clock leaving Update-DR while EXTEST or SAMPLE/PRELOAD is active. Shifting and pausing leave the pins unchanged.
- R9: Under EXTEST, `pad_out`, `pad_oe` and `core_in` come from update cells 3i+1, 3i+2 and 3i. Under SAMPLE/PRELOAD, IDCODE and the bypass opcodes they pass through `core_out`, `core_oe` and `pad_in`.
- R10: HIGHZ (101) forces every `pad_oe` bit to 0 and selects the bypass stage.
- R11: CLAMP (110) drives `pad_out` and `pad_oe` from the update stage and selects the bypass stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por | input | 1 | Synchronous active-high power-on reset |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in, sampled on rising edge |
| tdo | output | 1 | Serial data out, updated on falling edge |
| tdo_oe | output | 1 | High while shifting; the pad driver enable for `tdo` |
| core_out | input | NUM_IO | Output data from the core logic |
| core_oe | input | NUM_IO | Output enables from the core logic |
| pad_in | input | NUM_IO | Values seen at the pins |
| pad_out | output | NUM_IO | Data toward the pins |
| pad_oe | output | NUM_IO | Output enables toward the pins |
| core_in | output | NUM_IO | Pin values delivered to the core |

## Verification
The first serial bit of any scan is due at the falling edge after the rising edge that enters Shift-IR or Shift-DR. Each later bit is due one falling edge after the shift edge before it. The scoreboard therefore queues the expected bits before the scan starts, and the monitor pops one bit at each falling edge where `tdo_oe` is high. Instruction and update effects on the pins show up after the rising edge that leaves Update-IR or Update-DR, so the pin checks sample at the next falling edge. The edge-placement check looks at `tdo` half a nanosecond after a shifting rising edge, where it must still be unchanged, and again just after the falling edge.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

    localparam int IR_W         = 3;
    localparam int ID_W         = 32;
    localparam int CELLS_PER_IO = 3;
    localparam int CELL_IN      = 0;
    localparam int CELL_DO      = 1;
    localparam int CELL_OE      = 2;

    localparam logic [7:0] ID_FIXED_LOW = 8'h2F;

    typedef logic [IR_W-1:0] opcode_t;

    localparam opcode_t OP_EXTEST  = 3'b000;
    localparam opcode_t OP_SAMPLE  = 3'b001;
    localparam opcode_t OP_IDCODE  = 3'b010;
    localparam opcode_t OP_HIGHZ   = 3'b101;
    localparam opcode_t OP_CLAMP   = 3'b110;
    localparam opcode_t OP_BYPASS  = 3'b111;
    localparam opcode_t IR_CAPTURE = 3'b001;

    typedef enum logic [3:0] {
        S_RESET, S_IDLE,
        S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAUSE_DR, S_EX2_DR, S_UPD_DR,
        S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAUSE_IR, S_EX2_IR, S_UPD_IR
    } tap_state_t;

    typedef enum logic [1:0] {
        DR_BYPASS, DR_IDENT, DR_BOUNDARY
    } dr_sel_t;

    typedef struct packed {
        dr_sel_t sel;
        logic    drive_pins;
        logic    float_pins;
    } ir_decode_t;

    typedef struct packed {
        logic capture;
        logic shift;
        logic update;
    } scan_ctl_t;

    function automatic tap_state_t tap_next(input tap_state_t s, input logic tms);
        tap_state_t n;
        case (s)
            S_RESET:    n = tms ? S_RESET    : S_IDLE;
            S_IDLE:     n = tms ? S_SEL_DR   : S_IDLE;
            S_SEL_DR:   n = tms ? S_SEL_IR   : S_CAP_DR;
            S_CAP_DR:   n = tms ? S_EX1_DR   : S_SH_DR;
            S_SH_DR:    n = tms ? S_EX1_DR   : S_SH_DR;
            S_EX1_DR:   n = tms ? S_UPD_DR   : S_PAUSE_DR;
            S_PAUSE_DR: n = tms ? S_EX2_DR   : S_PAUSE_DR;
            S_EX2_DR:   n = tms ? S_UPD_DR   : S_SH_DR;
            S_UPD_DR:   n = tms ? S_SEL_DR   : S_IDLE;
            S_SEL_IR:   n = tms ? S_RESET    : S_CAP_IR;
            S_CAP_IR:   n = tms ? S_EX1_IR   : S_SH_IR;
            S_SH_IR:    n = tms ? S_EX1_IR   : S_SH_IR;
            S_EX1_IR:   n = tms ? S_UPD_IR   : S_PAUSE_IR;
            S_PAUSE_IR: n = tms ? S_EX2_IR   : S_PAUSE_IR;
            S_EX2_IR:   n = tms ? S_UPD_IR   : S_SH_IR;
            S_UPD_IR:   n = tms ? S_SEL_DR   : S_IDLE;
            default:    n = S_RESET;
        endcase
        return n;
    endfunction

    function automatic ir_decode_t ir_decode(input opcode_t op);
        ir_decode_t d;
        d.sel        = DR_BYPASS;
        d.drive_pins = 1'b0;
        d.float_pins = 1'b0;
        case (op)
            OP_EXTEST: begin
                d.sel        = DR_BOUNDARY;
                d.drive_pins = 1'b1;
            end
            OP_SAMPLE: d.sel        = DR_BOUNDARY;
            OP_IDCODE: d.sel        = DR_IDENT;
            OP_HIGHZ:  d.float_pins = 1'b1;
            OP_CLAMP:  d.drive_pins = 1'b1;
            default:   d.sel        = DR_BYPASS;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       por,
    input  logic       tms,
    output tap_state_t state,
    output logic       in_tlr,
    output scan_ctl_t  ir_ctl,
    output scan_ctl_t  dr_ctl
);

    always_ff @(posedge tck) begin
        if (por) state <= S_RESET;
        else     state <= tap_next(state, tms);
    end

    assign in_tlr = (state == S_RESET);

    always_comb begin
        ir_ctl.capture = (state == S_CAP_IR);
        ir_ctl.shift   = (state == S_SH_IR);
        ir_ctl.update  = (state == S_UPD_IR);
        dr_ctl.capture = (state == S_CAP_DR);
        dr_ctl.shift   = (state == S_SH_DR);
        dr_ctl.update  = (state == S_UPD_DR);
    end

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
    import scan_tap_pkg::*;
(
    input  logic      tck,
    input  logic      por,
    input  logic      tdi,
    input  logic      in_tlr,
    input  scan_ctl_t ctl,
    output opcode_t   ir_q,
    output logic      ir_so
);

    opcode_t ir_sh;

    always_ff @(posedge tck) begin
        if (por) begin
            ir_sh <= IR_CAPTURE;
            ir_q  <= OP_IDCODE;
        end else begin
            if (in_tlr)          ir_q <= OP_IDCODE;
            else if (ctl.update) ir_q <= ir_sh;

            if (ctl.capture)     ir_sh <= IR_CAPTURE;
            else if (ctl.shift)  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        end
    end

    assign ir_so = ir_sh[0];

endmodule

// File: rtl/scan_bsr.sv
module scan_bsr
    import scan_tap_pkg::*;
#(
    parameter int NUM_IO = 4
) (
    input  logic                             tck,
    input  logic                             por,
    input  logic                             tdi,
    input  logic                             sel,
    input  scan_ctl_t                        ctl,
    input  logic [NUM_IO-1:0]                pad_in,
    input  logic [NUM_IO-1:0]                core_out,
    input  logic [NUM_IO-1:0]                core_oe,
    output logic [CELLS_PER_IO*NUM_IO-1:0]   upd_q,
    output logic                             so
);

    localparam int LEN = CELLS_PER_IO * NUM_IO;

    logic [LEN-1:0] cap_vec;
    logic [LEN-1:0] sh_q;

    for (genvar i = 0; i < NUM_IO; i++) begin : g_cell
        assign cap_vec[CELLS_PER_IO*i + CELL_IN] = pad_in[i];
        assign cap_vec[CELLS_PER_IO*i + CELL_DO] = core_out[i];
        assign cap_vec[CELLS_PER_IO*i + CELL_OE] = core_oe[i];
    end

    always_ff @(posedge tck) begin
        if (por) begin
            sh_q  <= '0;
            upd_q <= '0;
        end else if (sel) begin
            if (ctl.capture)    sh_q <= cap_vec;
            else if (ctl.shift) sh_q <= {tdi, sh_q[LEN-1:1]};
            if (ctl.update)     upd_q <= sh_q;
        end
    end

    assign so = sh_q[0];

endmodule

// File: rtl/scan_tap_port.sv
module scan_tap_port
    import scan_tap_pkg::*;
#(
    parameter int         NUM_IO  = 4,
    parameter logic [3:0] ID_VER  = 4'h1,
    parameter logic [15:0] ID_PART = 16'hA5C3,
    parameter logic [3:0] ID_NUM  = 4'h3
) (
    input  logic              tck,
    input  logic              por,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    output logic              tdo_oe,
    input  logic [NUM_IO-1:0] core_out,
    input  logic [NUM_IO-1:0] core_oe,
    input  logic [NUM_IO-1:0] pad_in,
    output logic [NUM_IO-1:0] pad_out,
    output logic [NUM_IO-1:0] pad_oe,
    output logic [NUM_IO-1:0] core_in
);

    localparam int             BSR_LEN  = CELLS_PER_IO * NUM_IO;
    localparam logic [ID_W-1:0] ID_VALUE = {ID_VER, ID_PART, ID_NUM, ID_FIXED_LOW};

    tap_state_t           state;
    logic                 in_tlr;
    scan_ctl_t            ir_ctl;
    scan_ctl_t            dr_ctl;
    opcode_t              ir_q;
    logic                 ir_so;
    ir_decode_t           dec;
    logic [BSR_LEN-1:0]   bsr_upd;
    logic                 bsr_so;
    logic                 byp_q;
    logic [ID_W-1:0]      id_sh;
    logic                 dr_so;
    logic                 extest;
    logic                 tdo_q;
    logic                 tdo_en;

    scan_tap_fsm u_fsm (
        .tck    (tck),
        .por    (por),
        .tms    (tms),
        .state  (state),
        .in_tlr (in_tlr),
        .ir_ctl (ir_ctl),
        .dr_ctl (dr_ctl)
    );

    scan_tap_ir u_ir (
        .tck    (tck),
        .por    (por),
        .tdi    (tdi),
        .in_tlr (in_tlr),
        .ctl    (ir_ctl),
        .ir_q   (ir_q),
        .ir_so  (ir_so)
    );

    assign dec    = ir_decode(ir_q);
    assign extest = (ir_q == OP_EXTEST);

    scan_bsr #(.NUM_IO(NUM_IO)) u_bsr (
        .tck      (tck),
        .por      (por),
        .tdi      (tdi),
        .sel      (dec.sel == DR_BOUNDARY),
        .ctl      (dr_ctl),
        .pad_in   (pad_in),
        .core_out (core_out),
        .core_oe  (core_oe),
        .upd_q    (bsr_upd),
        .so       (bsr_so)
    );

    // One-bit bypass stage and identification shifter
    always_ff @(posedge tck) begin
        if (por) begin
            byp_q <= 1'b0;
            id_sh <= ID_VALUE;
        end else begin
            if (dec.sel == DR_BYPASS) begin
                if (dr_ctl.capture)    byp_q <= 1'b0;
                else if (dr_ctl.shift) byp_q <= tdi;
            end
            if (dec.sel == DR_IDENT) begin
                if (dr_ctl.capture)    id_sh <= ID_VALUE;
                else if (dr_ctl.shift) id_sh <= {tdi, id_sh[ID_W-1:1]};
            end
        end
    end

    always_comb begin
        case (dec.sel)
            DR_IDENT:    dr_so = id_sh[0];
            DR_BOUNDARY: dr_so = bsr_so;
            default:     dr_so = byp_q;
        endcase
    end

    // Serial output launched on the falling edge
    always_ff @(negedge tck) begin
        if (por) begin
            tdo_q  <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= ir_ctl.shift | dr_ctl.shift;
            tdo_q  <= ir_ctl.shift ? ir_so : (dr_ctl.shift ? dr_so : 1'b0);
        end
    end

    assign tdo    = tdo_q;
    assign tdo_oe = tdo_en;

    for (genvar i = 0; i < NUM_IO; i++) begin : g_pin
        assign pad_out[i] = dec.drive_pins ? bsr_upd[CELLS_PER_IO*i + CELL_DO] : core_out[i];
        assign pad_oe[i]  = dec.float_pins ? 1'b0 :
                            (dec.drive_pins ? bsr_upd[CELLS_PER_IO*i + CELL_OE] : core_oe[i]);
        assign core_in[i] = extest ? bsr_upd[CELLS_PER_IO*i + CELL_IN] : pad_in[i];
    end

endmodule

// File: rtl/scan_tap_checks.sv
module scan_tap_checks
    import scan_tap_pkg::*;
#(
    parameter int NUM_IO = 4
) (
    input logic                           tck,
    input logic                           por,
    input logic                           tms,
    input tap_state_t                     state,
    input opcode_t                        ir_q,
    input logic                           tdo_oe,
    input logic [NUM_IO-1:0]              pad_oe,
    input logic [CELLS_PER_IO*NUM_IO-1:0] upd
);

    logic [2:0] hi_cnt;

    always_ff @(posedge tck) begin
        if (por)                 hi_cnt <= 3'd0;
        else if (!tms)           hi_cnt <= 3'd0;
        else if (hi_cnt != 3'd5) hi_cnt <= hi_cnt + 3'd1;
    end

    a_r2_five_high_resets: assert property (@(posedge tck) disable iff (por)
        (hi_cnt == 3'd5) |-> (state == S_RESET));

    a_r1_tlr_loads_idcode: assert property (@(posedge tck) disable iff (por)
        (state == S_RESET) |=> (ir_q == OP_IDCODE));

    a_r4_tdo_enable_tracks_shift: assert property (@(posedge tck) disable iff (por)
        tdo_oe == ((state == S_SH_IR) || (state == S_SH_DR)));

    a_r8_update_only_in_update_dr: assert property (@(posedge tck) disable iff (por)
        (state != S_UPD_DR) |=> $stable(upd));

    a_r10_highz_floats_pins: assert property (@(posedge tck) disable iff (por)
        (ir_q == OP_HIGHZ) |-> (pad_oe == '0));

endmodule

bind scan_tap_port scan_tap_checks #(.NUM_IO(NUM_IO)) u_chk (
    .tck    (tck),
    .por    (por),
    .tms    (tms),
    .state  (state),
    .ir_q   (ir_q),
    .tdo_oe (tdo_oe),
    .pad_oe (pad_oe),
    .upd    (bsr_upd)
);

// File: tb/scan_tap_port_test.sv
`timescale 1ns/1ps
module scan_tap_port_test;

    localparam int N = 4;
    localparam int L = 3 * N;
    localparam logic [31:0] ID_EXP = {4'h1, 16'hA5C3, 4'h3, 8'h2F};
    localparam logic [2:0] C_EXTEST = 3'b000, C_SAMPLE = 3'b001, C_HIGHZ = 3'b101,
                           C_CLAMP = 3'b110, C_BYPASS = 3'b111;

    logic tck = 1'b0;
    logic por = 1'b1;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic [N-1:0] core_out = 4'b1100;
    logic [N-1:0] core_oe  = 4'b1001;
    logic [N-1:0] pad_in   = 4'b0011;
    wire tdo, tdo_oe;
    wire [N-1:0] pad_out, pad_oe, core_in;

    always #2 tck = ~tck;

    scan_tap_port #(.NUM_IO(N), .ID_VER(4'h1), .ID_PART(16'hA5C3), .ID_NUM(4'h3)) uut (
        .tck(tck), .por(por), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
        .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .core_in(core_in)
    );

    int checks = 0;
    int fails  = 0;

    typedef struct { logic val; int req; } exp_t;
    exp_t exp_q[$];

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: one expected serial bit per falling edge with tdo_oe high
    initial forever begin
        @(negedge tck);
        #1;
        if (tdo_oe) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R4: tdo_oe actual %b expected 0 (no scan pending)", tdo_oe);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (tdo !== e.val) begin
                    fails++;
                    $display("FAIL R%0d: tdo actual %b expected %b", e.req, tdo, e.val);
                end
            end
        end
    end

    initial begin
        #800000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    function automatic logic [L-1:0] mk(input logic [N-1:0] pi, input logic [N-1:0] po,
                                        input logic [N-1:0] oe);
        logic [L-1:0] v;
        for (int i = 0; i < N; i++) begin
            v[3*i]   = pi[i];
            v[3*i+1] = po[i];
            v[3*i+2] = oe[i];
        end
        return v;
    endfunction

    task automatic step(input logic m, input logic d);
        @(negedge tck);
        #1;
        tms = m;
        tdi = d;
    endtask

    task automatic settle();
        @(negedge tck);
        #1;
    endtask

    task automatic push_bits(input int n, input logic [63:0] bits, input int req);
        for (int k = 0; k < n; k++) exp_q.push_back('{bits[k], req});
    endtask

    task automatic ir_scan(input logic [2:0] op);
        push_bits(3, 64'b001, 5);  // R5 capture pattern
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int k = 0; k < 3; k++) step(k == 2, op[k]);
        step(1, 0); step(0, 0);
    endtask

    task automatic dr_scan(input int n, input logic [63:0] din, input logic [63:0] dexp, input int req);
        push_bits(n, dexp, req);
        step(1, 0); step(0, 0); step(0, 0);
        for (int k = 0; k < n; k++) step(k == n - 1, din[k]);
        step(1, 0); step(0, 0);
    endtask

    logic [L-1:0] pre1, pre2;

    initial begin
        pre1 = mk(4'b1001, 4'b0101, 4'b1110);
        pre2 = mk(4'b0110, 4'b1010, 4'b0111);
        repeat (4) @(negedge tck);
        #1;
        // R1 / R4 reset state
        chk("R4 tdo_oe after reset", tdo_oe, 0);
        chk("R4 tdo after reset", tdo, 0);
        chk("R9 pad_out passthrough at reset", pad_out, core_out);
        chk("R9 pad_oe passthrough at reset", pad_oe, core_oe);
        por = 1'b0;
        tms = 1'b0;

        // R1 identification word without instruction load
        dr_scan(32, 64'h0, ID_EXP, 1);

        // R5 + R6 bypass opcode 111
        ir_scan(C_BYPASS);
        dr_scan(8, 8'b1011_0010, {8'b1011_0010, 1'b0}, 6);

        // R6 unassigned opcodes act as bypass
        ir_scan(3'b011);
        dr_scan(6, 6'b110101, {6'b110101, 1'b0}, 6);
        ir_scan(3'b100);
        dr_scan(5, 5'b01101, {5'b01101, 1'b0}, 6);

        // R2: from Pause-IR, five TMS-high edges reach Test-Logic-Reset
        step(1, 0); step(1, 0); step(0, 0); step(1, 0); step(0, 0);
        repeat (5) step(1, 0);
        step(0, 0);
        dr_scan(32, 64'h0, ID_EXP, 2);

        // R7 capture under SAMPLE, preload, R9 passthrough
        ir_scan(C_SAMPLE);
        settle();
        chk("R9 pad_out under SAMPLE", pad_out, core_out);
        chk("R9 pad_oe under SAMPLE", pad_oe, core_oe);
        dr_scan(L, pre1, mk(pad_in, core_out, core_oe), 7);
        settle();
        chk("R9 pad_out under SAMPLE after preload", pad_out, core_out);
        chk("R9 core_in under SAMPLE", core_in, pad_in);

        // R9 EXTEST drives from update stage
        ir_scan(C_EXTEST);
        settle();
        chk("R9 pad_out under EXTEST", pad_out, 4'b0101);
        chk("R9 pad_oe under EXTEST", pad_oe, 4'b1110);
        chk("R9 core_in under EXTEST", core_in, 4'b1001);

        // R8 pins hold through shift and pause, change after Update-DR
        push_bits(L, mk(pad_in, core_out, core_oe), 7);
        step(1, 0); step(0, 0); step(0, 0);
        for (int k = 0; k < L; k++) step(k == L - 1, pre2[k]);
        step(0, 0);
        settle();
        chk("R8 pad_out held in Pause-DR", pad_out, 4'b0101);
        chk("R8 pad_oe held in Pause-DR", pad_oe, 4'b1110);
        step(1, 0); step(1, 0); step(0, 0);
        settle();
        chk("R8 pad_out after Update-DR", pad_out, 4'b1010);
        chk("R8 pad_oe after Update-DR", pad_oe, 4'b0111);
        chk("R8 core_in after Update-DR", core_in, 4'b0110);

        // R10 HIGHZ
        ir_scan(C_HIGHZ);
        settle();
        chk("R10 pad_oe under HIGHZ", pad_oe, 4'b0000);
        dr_scan(6, 6'b100111, {6'b100111, 1'b0}, 10);

        // R11 CLAMP
        ir_scan(C_CLAMP);
        settle();
        chk("R11 pad_out under CLAMP", pad_out, 4'b1010);
        chk("R11 pad_oe under CLAMP", pad_oe, 4'b0111);
        chk("R11 core_in under CLAMP", core_in, pad_in);
        dr_scan(5, 5'b11010, {5'b11010, 1'b0}, 11);

        // R3 edge placement on the bypass path
        push_bits(2, 64'b10, 3);
        step(1, 0); step(0, 0); step(0, 0);
        step(0, 1);
        @(posedge tck);
        #0.5;
        chk("R3 tdo unchanged after rising edge", tdo, 0);
        @(negedge tck);
        #1;
        chk("R3 tdo updated after falling edge", tdo, 1);
        tms = 1'b1;
        tdi = 1'b0;
        step(1, 0); step(0, 0);
        settle();
        chk("R4 tdo_oe low in Run-Test/Idle", tdo_oe, 0);
        chk("R4 all expected serial bits seen", exp_q.size(), 0);

        summary();
    end

endmodule